// File: doc/BRIEF.md
# Embedded Core Isolation Wrapper with Test Modes

This block sits between an embedded core and the logic that surrounds it on the chip. It can pass functional traffic straight through, or it can cut the core off from its neighbours so that either side can be tested alone. A short boundary register, with its own scan clock, active-low scan enable, serial input and serial output, holds the test values. Cells that face the functional input are placed first in the chain. Cells that face the functional output are placed after them.

Two static mode pins select the configuration. Normal operation connects the functional input to the core and the core output to the functional output. External test drives the functional output from the boundary register and samples the functional input, so the logic outside the core can be exercised. Internal test drives the core input from the boundary register and samples the core output, so the core itself can be exercised. Each cell has a shift stage and a separate update stage. The values driven into the core or onto the functional output therefore stay fixed while new data is shifted in, and change once, when shifting ends.

The parameter `DATA_W` sets the width of the functional input and of the functional output. The chain holds `2*DATA_W` cells, which is two cells at the default width of 1.

Top module: `core_test_wrapper`

## Requirements
- R1: While `wrst_n` is low, every shift stage and every update stage is cleared. After reset, with `mode_sel`=01 and `bnd_se_n`=1, `sys_out`, `core_drv` and `bnd_so` all read 0.
- R2: When `mode_sel`=00 (normal), `core_drv` equals `sys_in` and `sys_out` equals `core_obs` in the same cycle. This holds whatever `bnd_se_n` and `bnd_si` are doing.
- R3: `mode_sel`=11 is a reserved code. It routes data exactly as normal mode does and raises `mode_bad` for as long as it is applied. For every other code `mode_bad` is 0.
- R4: On each rising edge of `wck` with `bnd_se_n`=0, the chain shifts one place: `bnd_si` enters cell 0, cell 0 moves into cell 1, and `bnd_so` shows the last cell. A bit presented on `bnd_si` at one shifting edge appears on `bnd_so` after the second shifting edge.
- R5: While `bnd_se_n`=1, `bnd_so` reads 0.
- R6: Update stages load from the shift stages only at the first rising edge with `bnd_se_n`=1 that follows an edge with `bnd_se_n`=0. At every other edge they hold their value. As a result, `core_drv` in internal test and `sys_out` in external test do not change during shifting.
- R7: In external test (`mode_sel`=01), `sys_out` equals the update stage of the output cell and `core_drv` is 0. The input cell captures `sys_in` at each rising edge with `bnd_se_n`=1.
- R8: In internal test (`mode_sel`=10), `core_drv` equals the update stage of the input cell and `sys_out` is 0. The output cell captures `core_obs` at each rising edge with `bnd_se_n`=1.
- R9: The input cell holds its value instead of capturing during internal test. The output cell holds its value instead of capturing during external test. In normal mode and under the reserved code, both cells capture at each rising edge with `bnd_se_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wck | input | 1 | Boundary scan clock, active on its rising edge |
| wrst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Static mode: 00 normal, 01 external test, 10 internal test, 11 reserved |
| sys_in | input | DATA_W | Functional input arriving from the surrounding logic |
| sys_out | output | DATA_W | Functional output leaving toward the surrounding logic |
| core_drv | output | DATA_W | Input driven into the core |
| core_obs | input | DATA_W | Output produced by the core |
| bnd_si | input | 1 | Boundary chain serial input |
| bnd_so | output | 1 | Boundary chain serial output, 0 when not shifting |
| bnd_se_n | input | 1 | Boundary scan enable, 0 selects shifting |
| mode_bad | output | 1 | High while the reserved mode code is applied |

## Verification
A corrupted shift stage shows on `bnd_so` once shifting starts, after at most one shift edge per cell between it and the serial output. A wrong capture decision appears as a stale or foreign bit in the shifted-out stream during the next shift run. A faulty update strobe shows up within one edge of the end of shifting: either `core_drv` or `sys_out` moves while data is still being shifted in, or it fails to take the new value after the exit edge. Routing or decode faults are combinational, so they appear on `core_drv`, `sys_out` or `mode_bad` in the same cycle as the offending mode code.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

  // Mode codes carried on the two static select pins
  typedef enum logic [1:0] {
    WM_FUNC = 2'b00,
    WM_EXT  = 2'b01,
    WM_INT  = 2'b10,
    WM_RSVD = 2'b11
  } wmode_e;

  // Cells per functional bit: one facing the input, one facing the output
  localparam int CELLS_PER_BIT = 2;

endpackage

// File: rtl/wrap_mode_dec.sv
module wrap_mode_dec
  import wrap_pkg::*;
(
  input  logic [1:0] mode_pins,
  output logic       is_ext,
  output logic       is_int,
  output logic       is_rsvd
);

  wmode_e mode;
  assign mode = wmode_e'(mode_pins);

  always_comb begin
    is_ext  = 1'b0;
    is_int  = 1'b0;
    is_rsvd = 1'b0;
    unique case (mode)
      WM_EXT:  is_ext  = 1'b1;
      WM_INT:  is_int  = 1'b1;
      WM_RSVD: is_rsvd = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/wrap_scan_ctl.sv
module wrap_scan_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic se_n,
  output logic shift_en,
  output logic upd_en
);

  // Remembers whether the previous edge was a shifting edge
  logic was_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_shift <= 1'b0;
    else        was_shift <= ~se_n;
  end

  assign shift_en = ~se_n;
  assign upd_en   = se_n & was_shift;

endmodule

// File: rtl/wrap_bcell.sv
module wrap_bcell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic cap_en,
  input  logic upd_en,
  input  logic scan_d,
  input  logic cap_d,
  output logic sh_q,
  output logic upd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= 1'b0;
    else if (shift_en) sh_q <= scan_d;
    else if (cap_en)   sh_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_q <= 1'b0;
    else if (upd_en) upd_q <= sh_q;
  end

endmodule

// File: rtl/wrap_route.sv
module wrap_route #(
  parameter int DATA_W = 1
) (
  input  logic              is_ext,
  input  logic              is_int,
  input  logic [DATA_W-1:0] sys_in,
  input  logic [DATA_W-1:0] core_obs,
  input  logic [DATA_W-1:0] in_upd,
  input  logic [DATA_W-1:0] out_upd,
  output logic [DATA_W-1:0] sys_out,
  output logic [DATA_W-1:0] core_drv
);

  always_comb begin
    if (is_ext)      sys_out = out_upd;
    else if (is_int) sys_out = '0;
    else             sys_out = core_obs;
  end

  always_comb begin
    if (is_int)      core_drv = in_upd;
    else if (is_ext) core_drv = '0;
    else             core_drv = sys_in;
  end

endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import wrap_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              wck,
  input  logic              wrst_n,
  input  logic [1:0]        mode_sel,
  input  logic [DATA_W-1:0] sys_in,
  output logic [DATA_W-1:0] sys_out,
  output logic [DATA_W-1:0] core_drv,
  input  logic [DATA_W-1:0] core_obs,
  input  logic              bnd_si,
  output logic              bnd_so,
  input  logic              bnd_se_n,
  output logic              mode_bad
);

  localparam int CHAIN_LEN = CELLS_PER_BIT * DATA_W;

  logic is_ext, is_int, is_rsvd;
  logic shift_en, upd_en;
  logic [CHAIN_LEN-1:0] sh, upd, cap_d, cap_en, scan_d;
  logic [DATA_W-1:0] in_upd, out_upd;

  wrap_mode_dec u_dec (
    .mode_pins (mode_sel),
    .is_ext    (is_ext),
    .is_int    (is_int),
    .is_rsvd   (is_rsvd)
  );

  wrap_scan_ctl u_ctl (
    .clk      (wck),
    .rst_n    (wrst_n),
    .se_n     (bnd_se_n),
    .shift_en (shift_en),
    .upd_en   (upd_en)
  );

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign scan_d[i] = bnd_si;
      end else begin : g_link
        assign scan_d[i] = sh[i-1];
      end

      if (i < DATA_W) begin : g_in
        // Input-facing cell: observes the functional input
        assign cap_d[i]  = sys_in[i];
        assign cap_en[i] = ~is_int;
        assign in_upd[i] = upd[i];
      end else begin : g_out
        // Output-facing cell: observes the core output
        assign cap_d[i]           = core_obs[i-DATA_W];
        assign cap_en[i]          = ~is_ext;
        assign out_upd[i-DATA_W]  = upd[i];
      end

      wrap_bcell u_cell (
        .clk      (wck),
        .rst_n    (wrst_n),
        .shift_en (shift_en),
        .cap_en   (cap_en[i]),
        .upd_en   (upd_en),
        .scan_d   (scan_d[i]),
        .cap_d    (cap_d[i]),
        .sh_q     (sh[i]),
        .upd_q    (upd[i])
      );
    end
  endgenerate

  wrap_route #(.DATA_W(DATA_W)) u_route (
    .is_ext   (is_ext),
    .is_int   (is_int),
    .sys_in   (sys_in),
    .core_obs (core_obs),
    .in_upd   (in_upd),
    .out_upd  (out_upd),
    .sys_out  (sys_out),
    .core_drv (core_drv)
  );

  assign bnd_so   = bnd_se_n ? 1'b0 : sh[CHAIN_LEN-1];
  assign mode_bad = is_rsvd;

endmodule

// File: rtl/core_test_wrapper_chk.sv
module core_test_wrapper_chk #(
  parameter int DATA_W = 1
) (
  input logic              wck,
  input logic              wrst_n,
  input logic [1:0]        mode_sel,
  input logic [DATA_W-1:0] sys_in,
  input logic [DATA_W-1:0] sys_out,
  input logic [DATA_W-1:0] core_drv,
  input logic [DATA_W-1:0] core_obs,
  input logic              bnd_si,
  input logic              bnd_so,
  input logic              bnd_se_n,
  input logic              mode_bad
);

  logic [1:0] since_rst;
  always_ff @(posedge wck or negedge wrst_n) begin
    if (!wrst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  normal_route_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b00) |-> (core_drv == sys_in && sys_out == core_obs));

  // R3
  rsvd_flag_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    mode_bad == (mode_sel == 2'b11));

  // R3
  rsvd_route_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b11) |-> (core_drv == sys_in && sys_out == core_obs));

  // R5
  so_quiet_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    bnd_se_n |-> (bnd_so == 1'b0));

  // R6
  int_hold_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b10 && !bnd_se_n) |=> (mode_sel != 2'b10 || $stable(core_drv)));

  // R6
  ext_hold_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b01 && !bnd_se_n) |=> (mode_sel != 2'b01 || $stable(sys_out)));

  // R7
  ext_core_safe_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b01) |-> (core_drv == '0));

  // R8
  int_out_safe_chk: assert property (@(posedge wck) disable iff (!wrst_n)
    (mode_sel == 2'b10) |-> (sys_out == '0));

  generate
    if (DATA_W == 1) begin : g_two_cell
      // R4
      shift_path_chk: assert property (@(posedge wck) disable iff (!wrst_n)
        (since_rst >= 2'd2 && !bnd_se_n && !$past(bnd_se_n) && !$past(bnd_se_n, 2))
        |-> (bnd_so == $past(bnd_si, 2)));
    end
  endgenerate

endmodule

bind core_test_wrapper core_test_wrapper_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_core_test_wrapper.sv
module sim_core_test_wrapper;

  logic       wck = 1'b0;
  logic       wrst_n = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic [0:0] sys_in = 1'b0;
  logic [0:0] sys_out;
  logic [0:0] core_drv;
  logic [0:0] core_obs = 1'b0;
  logic       bnd_si = 1'b0;
  logic       bnd_so;
  logic       bnd_se_n = 1'b1;
  logic       mode_bad;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Output selectors for the scoreboard
  localparam int S_SO = 0, S_OUT = 1, S_DRV = 2, S_BAD = 3;

  typedef struct {
    string req;
    int    sig;
    logic  exp;
  } exp_t;

  exp_t sb[$];

  always #2 wck = ~wck;

  core_test_wrapper u0 (
    .wck      (wck),
    .wrst_n   (wrst_n),
    .mode_sel (mode_sel),
    .sys_in   (sys_in),
    .sys_out  (sys_out),
    .core_drv (core_drv),
    .core_obs (core_obs),
    .bnd_si   (bnd_si),
    .bnd_so   (bnd_so),
    .bnd_se_n (bnd_se_n),
    .mode_bad (mode_bad)
  );

  function automatic logic read_sig(int s);
    case (s)
      S_SO:    return bnd_so;
      S_OUT:   return sys_out[0];
      S_DRV:   return core_drv[0];
      default: return mode_bad;
    endcase
  endfunction

  // Monitor: at each falling edge, compare everything queued for this cycle
  initial begin
    forever begin
      @(negedge wck);
      while (sb.size() > 0) begin
        exp_t e;
        logic got;
        e   = sb.pop_front();
        got = read_sig(e.sig);
        checks++;
        if (got !== e.exp) begin
          errors++;
          $display("FAIL %s sig=%0d actual=%b expected=%b at %0t", e.req, e.sig, got, e.exp, $time);
        end
      end
    end
  end

  task automatic expect_at(string req, int sig, logic v);
    exp_t e;
    e.req = req; e.sig = sig; e.exp = v;
    sb.push_back(e);
  endtask

  // Driver: after a rising edge, apply the inputs for the next edge
  task automatic step(logic [1:0] m, logic se_n, logic si, logic fin, logic cobs);
    @(posedge wck);
    #1;
    mode_sel = m; bnd_se_n = se_n; bnd_si = si; sys_in = fin; core_obs = cobs;
  endtask

  initial begin
    // Reset in external test, not shifting
    step(2'b01, 1, 0, 1, 1);
    expect_at("R1", S_OUT, 1'b0);
    expect_at("R1", S_DRV, 1'b0);
    expect_at("R1", S_SO,  1'b0);
    step(2'b01, 1, 0, 0, 0);
    wrst_n = 1'b1;

    // External test: shift 1,1,0
    step(2'b01, 1, 0, 0, 0);
    expect_at("R1", S_OUT, 1'b0);
    step(2'b01, 0, 1, 0, 0);
    expect_at("R4", S_SO, 1'b0);
    step(2'b01, 0, 1, 0, 0);
    expect_at("R4", S_SO, 1'b0);
    step(2'b01, 0, 0, 0, 0);
    expect_at("R4", S_SO, 1'b1);
    expect_at("R6", S_OUT, 1'b0);
    step(2'b01, 1, 0, 1, 0);
    expect_at("R5", S_SO, 1'b0);
    expect_at("R6", S_OUT, 1'b0);
    // Exit edge: update, input cell captures sys_in=1
    step(2'b01, 0, 0, 1, 0);
    expect_at("R7", S_OUT, 1'b1);
    expect_at("R7", S_DRV, 1'b0);
    expect_at("R9", S_SO,  1'b1);
    step(2'b01, 0, 0, 0, 0);
    expect_at("R7", S_SO,  1'b1);
    expect_at("R6", S_OUT, 1'b1);
    step(2'b01, 1, 0, 0, 0);
    expect_at("R6", S_OUT, 1'b1);
    expect_at("R5", S_SO,  1'b0);
    step(2'b01, 1, 0, 0, 0);
    expect_at("R6", S_OUT, 1'b0);

    // Internal test
    step(2'b10, 1, 0, 0, 0);
    expect_at("R8", S_DRV, 1'b0);
    expect_at("R8", S_OUT, 1'b0);
    step(2'b10, 0, 1, 0, 0);
    expect_at("R6", S_DRV, 1'b0);
    step(2'b10, 1, 0, 0, 1);
    expect_at("R6", S_DRV, 1'b0);
    expect_at("R5", S_SO,  1'b0);
    step(2'b10, 0, 0, 0, 0);
    expect_at("R8", S_DRV, 1'b1);
    expect_at("R8", S_OUT, 1'b0);
    expect_at("R8", S_SO,  1'b1);
    step(2'b10, 0, 0, 0, 0);
    expect_at("R9", S_SO,  1'b1);
    expect_at("R6", S_DRV, 1'b1);
    step(2'b10, 1, 0, 0, 0);
    expect_at("R5", S_SO, 1'b0);

    // Reserved code
    step(2'b11, 1, 0, 1, 0);
    expect_at("R3", S_BAD, 1'b1);
    expect_at("R3", S_DRV, 1'b1);
    expect_at("R3", S_OUT, 1'b0);
    step(2'b11, 1, 0, 0, 1);
    expect_at("R3", S_DRV, 1'b0);
    expect_at("R3", S_OUT, 1'b1);

    // Normal mode, also while shifting
    step(2'b00, 1, 0, 1, 0);
    expect_at("R3", S_BAD, 1'b0);
    expect_at("R2", S_DRV, 1'b1);
    expect_at("R2", S_OUT, 1'b0);
    step(2'b00, 0, 1, 0, 1);
    expect_at("R2", S_DRV, 1'b0);
    expect_at("R2", S_OUT, 1'b1);
    step(2'b00, 0, 0, 1, 1);
    expect_at("R2", S_DRV, 1'b1);
    expect_at("R2", S_OUT, 1'b1);
    step(2'b00, 1, 0, 0, 0);
    expect_at("R2", S_DRV, 1'b0);
    expect_at("R2", S_OUT, 1'b0);

    @(posedge wck);
    @(posedge wck);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule